// File: doc/BRIEF.md
# Vertical Lane Swap Remapper

This block sits between a memory controller and one die of a stacked DRAM. It routes the controller's data and address bits over a set of vertical interconnect lanes. Any lane can be marked faulty. A faulty lane is rerouted onto a standby lane that is fixed at design time. Each standby lane is an ordinary data lane. The standby lane's own data bits are also kept as a copy in ECC space through a side-channel port. When a swap takes over a standby lane, reads get that lane's bits from the copy. The result is that the logical data width and the full address reach survive the loss of a lane.

Software writes a per-lane fault mask into a pending register. The mask only reaches the steering logic while the bus reports idle, and a one-cycle acknowledge confirms each such update. The muxing in both directions is combinational and works from the last committed mapping. Two faulty lanes may compete for the same standby lane. In that case the lower-numbered lane gets it, the other lane stays unswapped, and a conflict flag is raised.

Top module: `tsv_lane_remap`

## Requirements
- R1: After reset no swap is active, `phyTxLanes` equals `{wrAddr, wrData}`, `rdData` equals `phyRxLanes`, and `swapConflict` and `cfgAck` are low.
- R2: A mask loaded with `cfgWrEn` changes nothing until a cycle with `busIdle` high. At that clock edge it becomes the active mapping. In the following cycle `cfgAck` is high for one cycle. While `busIdle` stays low the mapping, `cfgAck` and `swapConflict` stay unchanged.
- R3: Lane numbering: lane j for j < DATA_W carries `wrData[j]`, and lane DATA_W+j carries `wrAddr[j]`. The standby lanes are DATA_W-NUM_STBY .. DATA_W-1. The standby for a non-standby lane i is lane DATA_W-NUM_STBY + (i mod NUM_STBY). On write, a swapped lane's logical bit is driven on its standby lane.
- R4: Address lanes are swappable under the same rule as data lanes.
- R5: `phyWrEn` and `repWrEn` both equal `wrValid` in the same cycle, and `repWrBits[k]` always equals `wrData[DATA_W-NUM_STBY+k]`.
- R6: On read, a swapped data lane d returns `phyRxLanes` of its standby lane in `rdData[d]`.
- R7: On read, standby lane DATA_W-NUM_STBY+k returns `repRdBits[k]` when a swap occupies it or when that standby lane is itself marked faulty.
- R8: Lanes claim standby slots in ascending index order. A faulty standby lane holds its own slot. A lane whose slot is already taken is not swapped: its bit is read raw and its standby lane keeps its own bit. `swapConflict` is high from that commit until a commit without conflict.
- R9: Lanes that neither are swapped nor lend a slot pass through unchanged in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Load fault mask into pending register |
| cfgFaultMask | input | DATA_W+ADDR_W | One fault bit per lane |
| busIdle | input | 1 | No transaction in flight; pending mask may commit |
| cfgAck | output | 1 | One-cycle pulse after a commit |
| swapConflict | output | 1 | Active mapping had a standby collision |
| wrValid | input | 1 | Logical write beat valid |
| wrData | input | DATA_W | Logical write data |
| wrAddr | input | ADDR_W | Logical address |
| phyWrEn | output | 1 | Physical write strobe |
| phyTxLanes | output | DATA_W+ADDR_W | Physical lanes toward the die |
| repWrEn | output | 1 | Replica write strobe |
| repWrBits | output | NUM_STBY | Standby-position bits to the ECC copy |
| phyRxLanes | input | DATA_W | Physical data lanes from the die |
| repRdBits | input | NUM_STBY | Replica bits read back from ECC space |
| rdData | output | DATA_W | Repaired logical read data |

## Verification
The bench builds the block with DATA_W=16, ADDR_W=8 and NUM_STBY=4. With these values lanes 12..15 are the standby lanes, and each slot is shared by three data lanes and two address lanes. That makes address-lane swaps and collisions reachable with small masks. Masks used include a clean pair of one data lane and one address lane, a three-way collision on slot 0, a faulty standby on its own, and a faulty standby with a lane trying to borrow it. Each mask is checked before and after its idle commit.

// File: rtl/tsv_lane_remap_pkg.sv
package tsv_lane_remap_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic commit;    // latch resolved mapping this edge
    logic conflict;  // resolved mapping has a standby collision
  } remapStrobe_t;

endpackage

// File: rtl/tsv_lane_remap_ctrl.sv
module tsv_lane_remap_ctrl
  import tsv_lane_remap_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 16,
  parameter int NUM_STBY = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWrEn,
  input  logic [NUM_LANES-1:0] cfgFaultMask,
  input  logic                busIdle,
  output remapStrobe_t        stb,
  output logic [NUM_LANES-1:0] swapNext,
  output logic [NUM_STBY-1:0] repNext,
  output logic                cfgAck
);
  localparam int NUM_LANES = DATA_W + ADDR_W;
  localparam int STBY_BASE = DATA_W - NUM_STBY;

  logic [NUM_LANES-1:0] pendMask;
  logic                 pendValid;
  logic                 ackQ;
  logic                 conflictNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendMask  <= '0;
      pendValid <= 1'b0;
      ackQ      <= 1'b0;
    end else begin
      ackQ <= pendValid && busIdle;
      if (cfgWrEn) begin
        pendMask  <= cfgFaultMask;
        pendValid <= 1'b1;
      end else if (pendValid && busIdle) begin
        pendValid <= 1'b0;
      end
    end
  end

  // Slot allocation: faulty standby lanes hold their own slot first,
  // then lanes claim slots in ascending index order.
  always_comb begin
    logic [NUM_STBY-1:0] taken;
    taken        = '0;
    swapNext     = '0;
    conflictNext = 1'b0;
    for (int k = 0; k < NUM_STBY; k++) begin
      taken[k] = pendMask[STBY_BASE + k];
    end
    for (int i = 0; i < NUM_LANES; i++) begin
      if (pendMask[i] && !(i >= STBY_BASE && i < DATA_W)) begin
        if (taken[i % NUM_STBY]) begin
          conflictNext = 1'b1;
        end else begin
          taken[i % NUM_STBY] = 1'b1;
          swapNext[i]         = 1'b1;
        end
      end
    end
    repNext = taken;
  end

  assign stb.commit   = pendValid && busIdle;
  assign stb.conflict = conflictNext;
  assign cfgAck       = ackQ;

endmodule

// File: rtl/tsv_lane_remap_dp.sv
module tsv_lane_remap_dp
  import tsv_lane_remap_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 16,
  parameter int NUM_STBY = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  remapStrobe_t         stb,
  input  logic [NUM_LANES-1:0] swapNext,
  input  logic [NUM_STBY-1:0]  repNext,
  input  logic                 wrValid,
  input  logic [DATA_W-1:0]    wrData,
  input  logic [ADDR_W-1:0]    wrAddr,
  output logic                 phyWrEn,
  output logic [NUM_LANES-1:0] phyTxLanes,
  output logic                 repWrEn,
  output logic [NUM_STBY-1:0]  repWrBits,
  input  logic [DATA_W-1:0]    phyRxLanes,
  input  logic [NUM_STBY-1:0]  repRdBits,
  output logic [DATA_W-1:0]    rdData,
  output logic                 swapConflict
);
  localparam int NUM_LANES = DATA_W + ADDR_W;
  localparam int STBY_BASE = DATA_W - NUM_STBY;

  logic [NUM_LANES-1:0] swapOn;
  logic [NUM_STBY-1:0]  repOn;
  logic                 conflictQ;
  logic [NUM_LANES-1:0] logical;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      swapOn    <= '0;
      repOn     <= '0;
      conflictQ <= 1'b0;
    end else if (stb.commit) begin
      swapOn    <= swapNext;
      repOn     <= repNext;
      conflictQ <= stb.conflict;
    end
  end

  assign logical      = {wrAddr, wrData};
  assign phyWrEn      = wrValid;
  assign repWrEn      = wrValid;
  assign swapConflict = conflictQ;

  // Write direction: a standby lane carries the bit of the lane borrowing it
  always_comb begin
    phyTxLanes = logical;
    for (int i = 0; i < NUM_LANES; i++) begin
      if (swapOn[i]) begin
        phyTxLanes[STBY_BASE + (i % NUM_STBY)] = logical[i];
      end
    end
  end

  genvar gk, gd;
  generate
    for (gk = 0; gk < NUM_STBY; gk++) begin : g_rep
      assign repWrBits[gk] = wrData[STBY_BASE + gk];
    end
    for (gd = 0; gd < DATA_W; gd++) begin : g_rd
      if (gd >= STBY_BASE) begin : g_stby
        assign rdData[gd] = repOn[gd - STBY_BASE] ? repRdBits[gd - STBY_BASE]
                                                  : phyRxLanes[gd];
      end else begin : g_norm
        localparam int ALT = STBY_BASE + (gd % NUM_STBY);
        assign rdData[gd] = swapOn[gd] ? phyRxLanes[ALT] : phyRxLanes[gd];
      end
    end
  endgenerate

endmodule

// File: rtl/tsv_lane_remap.sv
module tsv_lane_remap
  import tsv_lane_remap_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 16,
  parameter int NUM_STBY = 4
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       cfgWrEn,
  input  logic [DATA_W+ADDR_W-1:0]   cfgFaultMask,
  input  logic                       busIdle,
  output logic                       cfgAck,
  output logic                       swapConflict,
  input  logic                       wrValid,
  input  logic [DATA_W-1:0]          wrData,
  input  logic [ADDR_W-1:0]          wrAddr,
  output logic                       phyWrEn,
  output logic [DATA_W+ADDR_W-1:0]   phyTxLanes,
  output logic                       repWrEn,
  output logic [NUM_STBY-1:0]        repWrBits,
  input  logic [DATA_W-1:0]          phyRxLanes,
  input  logic [NUM_STBY-1:0]        repRdBits,
  output logic [DATA_W-1:0]          rdData
);
  localparam int NUM_LANES = DATA_W + ADDR_W;

  remapStrobe_t         stb;
  logic [NUM_LANES-1:0] swapNext;
  logic [NUM_STBY-1:0]  repNext;

  tsv_lane_remap_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_STBY(NUM_STBY)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgFaultMask(cfgFaultMask),
    .busIdle(busIdle), .stb(stb), .swapNext(swapNext), .repNext(repNext),
    .cfgAck(cfgAck)
  );

  tsv_lane_remap_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_STBY(NUM_STBY)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .swapNext(swapNext), .repNext(repNext),
    .wrValid(wrValid), .wrData(wrData), .wrAddr(wrAddr), .phyWrEn(phyWrEn),
    .phyTxLanes(phyTxLanes), .repWrEn(repWrEn), .repWrBits(repWrBits),
    .phyRxLanes(phyRxLanes), .repRdBits(repRdBits), .rdData(rdData),
    .swapConflict(swapConflict)
  );

endmodule

// File: rtl/tsv_lane_remap_chk.sv
module tsv_lane_remap_chk (
  input logic clk,
  input logic rstN,
  input logic busIdle,
  input logic cfgAck,
  input logic swapConflict,
  input logic wrValid,
  input logic phyWrEn,
  input logic repWrEn
);
  // R2: an acknowledge only follows an idle cycle
  p_ack_after_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    cfgAck |-> $past(busIdle));

  // R2: nothing commits while the bus is busy
  p_hold_when_busy_r2: assert property (@(posedge clk) disable iff (!rstN)
    !busIdle |=> (!cfgAck && $stable(swapConflict)));

  // R5: physical and replica write strobes move together with the request
  p_wr_strobes_r5: assert property (@(posedge clk) disable iff (!rstN)
    (phyWrEn == wrValid) && (repWrEn == phyWrEn));

  // R8: the conflict flag only rises on an idle commit
  p_conflict_commit_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(swapConflict) |-> $past(busIdle));
endmodule

bind tsv_lane_remap tsv_lane_remap_chk u_chk (
  .clk(clk), .rstN(rstN), .busIdle(busIdle), .cfgAck(cfgAck),
  .swapConflict(swapConflict), .wrValid(wrValid), .phyWrEn(phyWrEn),
  .repWrEn(repWrEn)
);

// File: tb/tsv_lane_remap_bench.sv
`timescale 1ns/1ps
module tsv_lane_remap_bench;
  localparam int DW = 16;
  localparam int AW = 8;
  localparam int NS = 4;
  localparam int NL = DW + AW;
  localparam int SB = DW - NS;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrEn = 1'b0;
  logic [NL-1:0] cfgFaultMask = '0;
  logic busIdle = 1'b0;
  logic cfgAck, swapConflict;
  logic wrValid = 1'b0;
  logic [DW-1:0] wrData = '0;
  logic [AW-1:0] wrAddr = '0;
  logic phyWrEn, repWrEn;
  logic [NL-1:0] phyTxLanes;
  logic [NS-1:0] repWrBits;
  logic [DW-1:0] phyRxLanes = '0;
  logic [NS-1:0] repRdBits = '0;
  logic [DW-1:0] rdData;

  always #4 clk = ~clk;  // 125 MHz

  tsv_lane_remap #(.DATA_W(DW), .ADDR_W(AW), .NUM_STBY(NS)) u_tsv_lane_remap (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgFaultMask(cfgFaultMask),
    .busIdle(busIdle), .cfgAck(cfgAck), .swapConflict(swapConflict),
    .wrValid(wrValid), .wrData(wrData), .wrAddr(wrAddr), .phyWrEn(phyWrEn),
    .phyTxLanes(phyTxLanes), .repWrEn(repWrEn), .repWrBits(repWrBits),
    .phyRxLanes(phyRxLanes), .repRdBits(repRdBits), .rdData(rdData)
  );

  typedef struct {
    logic [NL-1:0] tx;
    logic [DW-1:0] rd;
    logic [NS-1:0] rep;
    logic          wen;
    logic          conf;
    logic          ack;
    string         tag;
  } expItem_t;

  expItem_t q[$];
  event     evItem;
  int       nVec = 0;
  int       nFail = 0;
  bit       done = 1'b0;

  // reference model of the committed mapping
  logic [NL-1:0] mSwap = '0;
  logic [NS-1:0] mRep  = '0;
  logic          mConf = 1'b0;

  task automatic modelCommit(input logic [NL-1:0] m);
    mSwap = '0; mRep = '0; mConf = 1'b0;
    for (int k = 0; k < NS; k++) mRep[k] = m[SB + k];
    for (int i = 0; i < NL; i++) begin
      if (m[i] && !(i >= SB && i < DW)) begin
        if (mRep[i % NS]) mConf = 1'b1;
        else begin mRep[i % NS] = 1'b1; mSwap[i] = 1'b1; end
      end
    end
  endtask

  task automatic drive(input logic [DW-1:0] d, input logic [AW-1:0] a,
                       input logic [DW-1:0] rx, input logic [NS-1:0] rp,
                       input logic wv, input logic idle, input logic ack,
                       input string tag);
    expItem_t e;
    logic [NL-1:0] lg;
    @(negedge clk);
    cfgWrEn = 1'b0; wrData = d; wrAddr = a; phyRxLanes = rx;
    repRdBits = rp; wrValid = wv; busIdle = idle;
    #1;
    lg = {a, d};
    e.tx = lg;
    for (int i = 0; i < NL; i++) if (mSwap[i]) e.tx[SB + (i % NS)] = lg[i];
    for (int j = 0; j < DW; j++) begin
      if (mSwap[j]) e.rd[j] = rx[SB + (j % NS)];
      else if (j >= SB && mRep[j - SB]) e.rd[j] = rp[j - SB];
      else e.rd[j] = rx[j];
    end
    e.rep = d[DW-1:SB];
    e.wen = wv; e.conf = mConf; e.ack = ack; e.tag = tag;
    q.push_back(e);
    ->evItem;
  endtask

  task automatic randVec(input logic idle, input string tag);
    drive(DW'($urandom()), AW'($urandom()), DW'($urandom()), NS'($urandom()),
          1'($urandom()), idle, 1'b0, tag);
  endtask

  // R2: load mask, hold busy, then commit through an idle cycle
  task automatic configure(input logic [NL-1:0] m, input string tag);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgFaultMask = m; busIdle = 1'b0;
    randVec(1'b0, {"R2 busy hold ", tag});
    randVec(1'b0, {"R2 busy hold ", tag});
    randVec(1'b1, {"R2 idle cycle ", tag});
    modelCommit(m);
    drive(DW'($urandom()), AW'($urandom()), DW'($urandom()), NS'($urandom()),
          1'b1, 1'b0, 1'b1, {"R2 ack ", tag});
  endtask

  // monitor: pop expected items and compare with the outputs
  initial begin
    forever begin
      @(evItem);
      while (q.size() > 0) begin
        expItem_t e;
        e = q.pop_front();
        nVec++;
        if (phyTxLanes !== e.tx || rdData !== e.rd || repWrBits !== e.rep ||
            phyWrEn !== e.wen || repWrEn !== e.wen || swapConflict !== e.conf ||
            cfgAck !== e.ack) begin
          nFail++;
          $display("FAIL %s: tx=%h/%h rd=%h/%h rep=%h/%h wen=%b%b/%b conf=%b/%b ack=%b/%b (actual/expected)",
                   e.tag, phyTxLanes, e.tx, rdData, e.rd, repWrBits, e.rep,
                   phyWrEn, repWrEn, e.wen, swapConflict, e.conf, cfgAck, e.ack);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: run did not complete (actual hung, expected finish)");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
      $finish;
    end
  end

  initial begin
    logic [NL-1:0] m;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    // R1 reset state, R9 pass-through
    drive('0, '0, '0, '0, 1'b0, 1'b0, 1'b0, "R1 reset zeros");
    drive('1, '1, '1, '1, 1'b1, 1'b0, 1'b0, "R1 R9 all ones");
    for (int n = 0; n < 4; n++) randVec(1'b0, "R1 R5 R9 no faults");
    // R3 R4: data lane 2 -> lane 14, address lane 19 (addr bit 3) -> lane 15
    m = '0; m[2] = 1'b1; m[19] = 1'b1;
    configure(m, "lanes 2,19");
    for (int n = 0; n < 8; n++) randVec(1'b0, "R3 R4 R5 R6 R7 R9 swap pair");
    drive(16'h0004, 8'h08, 16'h4000, 4'b0100, 1'b1, 1'b0, 1'b0, "R3 R4 R6 R7 walk");
    // R8: lanes 0,4,16 all want slot 0, lane 0 wins
    m = '0; m[0] = 1'b1; m[4] = 1'b1; m[16] = 1'b1;
    configure(m, "R8 collision 0,4,16");
    for (int n = 0; n < 6; n++) randVec(1'b0, "R8 collision lane 4 raw");
    // R7 R8: faulty standby 13 alone clears conflict
    m = '0; m[13] = 1'b1;
    configure(m, "R7 R8 standby 13");
    for (int n = 0; n < 4; n++) randVec(1'b0, "R7 standby 13 replica");
    // R8: lane 5 tries to borrow the faulty standby 13
    m = '0; m[13] = 1'b1; m[5] = 1'b1;
    configure(m, "R8 borrow faulty standby");
    for (int n = 0; n < 4; n++) randVec(1'b0, "R8 lane 5 rejected");
    // R2 R9: clear all faults
    configure('0, "R2 clear");
    for (int n = 0; n < 4; n++) randVec(1'b0, "R9 cleared pass-through");
    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end

endmodule